// File: doc/BRIEF.md
# SIMD Branch Divergence Mask Unit

This block controls which lanes of an eight-lane SIMD group may write back results while the group runs an if/else region. All lanes share one instruction stream, so the two sides of a branch cannot run at the same time. The block runs them one after the other. First the taken path runs with only the lanes whose condition is true. Then the else path runs with only the false lanes. Finally, one reconvergence cycle re-enables every lane that was active when the branch was entered.

A branch region starts with a one-cycle `start_i` pulse. The pulse carries three things: the per-lane condition, the mask active at entry, and the length in cycles of each path. If a path has no active lanes, or its length is zero, the block skips that phase entirely.

Two running counters measure utilisation. One counts the lane-slots that did useful work. The other counts all lane-slots spent inside branch regions. With a single true lane, the taken path does useful work in only one of eight slots.

Top module: `simd_branch_mask`

## Requirements
- R1: After reset, `phase_o` is 0 (idle), `mask_o` is 0, `busy_o` is 0 and both counters are 0.
- R2: A `start_i` pulse sampled while idle makes the next cycle enter the taken phase (`phase_o`=1). The taken phase lasts `then_len_i` cycles, with `mask_o` = `cond_i` AND `entry_mask_i`.
- R3: The else phase (`phase_o`=2) follows the taken phase, or directly follows the start if the taken phase is skipped. It lasts `else_len_i` cycles, with `mask_o` = NOT `cond_i` AND `entry_mask_i`.
- R4: Reconvergence (`phase_o`=3) follows the last branch phase and lasts exactly one cycle, with `mask_o` equal to the saved entry mask. The block then returns to idle.
- R5: A phase whose lane mask is all zero, or whose length is zero, is skipped and takes no cycles. If both phases are skipped, reconvergence follows the start directly.
- R6: A lane that is 0 in the entry mask is 0 in `mask_o` in every phase of that region.
- R7: A `start_i` pulse while `busy_o` is 1 is ignored. The phase sequence and masks of the running region are unchanged.
- R8: In every non-idle cycle, `total_o` grows by 8 and `useful_o` grows by the number of ones in `mask_o`. Both counters hold their value while idle.
- R9: While idle, `mask_o` is 0 and `busy_o` is 0. In every other phase, `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a branch region (taken when idle) |
| cond_i | input | 8 | Per-lane branch condition |
| entry_mask_i | input | 8 | Lanes active on branch entry |
| then_len_i | input | 8 | Taken-path length in cycles |
| else_len_i | input | 8 | Else-path length in cycles |
| mask_o | output | 8 | Lane writeback enable |
| phase_o | output | 2 | 0 idle, 1 taken, 2 else, 3 reconverge |
| busy_o | output | 1 | Branch region in progress |
| useful_o | output | 32 | Accumulated active lane-slots |
| total_o | output | 32 | Accumulated lane-slots in branch regions |

## Verification
A corrupted remaining-cycle count shows on `phase_o` in the cycle when a phase should end: the phase either ends early or runs too long. A wrong saved mask shows on `mask_o` in the first cycle of the affected phase. A wrong skip decision adds or removes whole phases, so the sequence of phases differs from the expected one within one cycle. Counter faults show in the totals sampled right after the block returns to idle. The bench therefore checks every cycle of each region as well as the counter deltas.

// File: rtl/simd_branch_pkg.sv
package simd_branch_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_THEN = 2'd1,
    PH_ELSE = 2'd2,
    PH_JOIN = 2'd3
  } phase_e;

  function automatic int unsigned lane_count(input logic [63:0] v, input int unsigned n);
    int unsigned c;
    c = 0;
    for (int unsigned i = 0; i < n; i++) c += int'(v[i]);
    return c;
  endfunction
endpackage

// File: rtl/sbm_mask_split.sv
module sbm_mask_split
  import simd_branch_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LANES-1:0] cond_i,
  input  logic [LANES-1:0] entry_i,
  input  phase_e           phase_i,
  output logic             then_any_o,
  output logic             else_any_o,
  output logic [LANES-1:0] mask_o
);
  logic [LANES-1:0] then_c, else_c;
  logic [LANES-1:0] entry_q, then_q, else_q;

  assign then_c     = cond_i & entry_i;
  assign else_c     = ~cond_i & entry_i;
  assign then_any_o = |then_c;
  assign else_any_o = |else_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_q <= '0;
      then_q  <= '0;
      else_q  <= '0;
    end else if (load_i) begin
      entry_q <= entry_i;
      then_q  <= then_c;
      else_q  <= else_c;
    end
  end

  always_comb begin
    unique case (phase_i)
      PH_THEN: mask_o = then_q;
      PH_ELSE: mask_o = else_q;
      PH_JOIN: mask_o = entry_q;
      default: mask_o = '0;
    endcase
  end

  // R6: never enable a lane absent at entry
  a_r6_subset_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o & ~entry_q) == '0);
endmodule

// File: rtl/sbm_phase_seq.sv
module sbm_phase_seq
  import simd_branch_pkg::*;
#(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             then_any_i,
  input  logic             else_any_i,
  input  logic [LEN_W-1:0] then_len_i,
  input  logic [LEN_W-1:0] else_len_i,
  output logic             load_o,
  output phase_e           phase_o
);
  phase_e           phase_q, phase_d;
  logic [LEN_W-1:0] rem_q, rem_d, else_len_q, else_len_d;
  logic             else_go_q, else_go_d;
  logic             then_go, else_go;

  assign load_o  = start_i && (phase_q == PH_IDLE);
  assign then_go = then_any_i && (then_len_i != '0);
  assign else_go = else_any_i && (else_len_i != '0);
  assign phase_o = phase_q;

  always_comb begin
    phase_d    = phase_q;
    rem_d      = rem_q;
    else_len_d = else_len_q;
    else_go_d  = else_go_q;
    unique case (phase_q)
      PH_IDLE: if (load_o) begin
        else_go_d  = else_go;
        else_len_d = else_len_i;
        if (then_go) begin
          phase_d = PH_THEN;
          rem_d   = then_len_i - 1'b1;
        end else if (else_go) begin
          phase_d = PH_ELSE;
          rem_d   = else_len_i - 1'b1;
        end else begin
          phase_d = PH_JOIN;
        end
      end
      PH_THEN: if (rem_q == '0) begin
        if (else_go_q) begin
          phase_d = PH_ELSE;
          rem_d   = else_len_q - 1'b1;
        end else begin
          phase_d = PH_JOIN;
        end
      end else begin
        rem_d = rem_q - 1'b1;
      end
      PH_ELSE: if (rem_q == '0) phase_d = PH_JOIN;
               else rem_d = rem_q - 1'b1;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      rem_q      <= '0;
      else_len_q <= '0;
      else_go_q  <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      rem_q      <= rem_d;
      else_len_q <= else_len_d;
      else_go_q  <= else_go_d;
    end
  end

  a_r4_join_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_JOIN |=> phase_q == PH_IDLE);
  a_r7_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ELSE && rem_q != '0) |=> phase_q == PH_ELSE);
  a_r2_idle_leaves_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && !start_i) |=> phase_q == PH_IDLE);
endmodule

// File: rtl/sbm_util_count.sv
module sbm_util_count
  import simd_branch_pkg::*;
#(
  parameter int unsigned LANES = 8,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  phase_e           phase_i,
  input  logic [LANES-1:0] mask_i,
  output logic [CNT_W-1:0] useful_o,
  output logic [CNT_W-1:0] total_o
);
  localparam logic [CNT_W-1:0] LANE_STEP = CNT_W'(LANES);
  logic [CNT_W-1:0] pop;

  assign pop = CNT_W'(lane_count(64'(mask_i), LANES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      useful_o <= '0;
      total_o  <= '0;
    end else if (phase_i != PH_IDLE) begin
      useful_o <= useful_o + pop;
      total_o  <= total_o + LANE_STEP;
    end
  end

  a_r8_total_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i != PH_IDLE |=> total_o == $past(total_o) + LANE_STEP);
  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == PH_IDLE |=> $stable(useful_o) && $stable(total_o));
endmodule

// File: rtl/simd_branch_mask.sv
module simd_branch_mask
  import simd_branch_pkg::*;
#(
  parameter int unsigned LANES = 8,
  parameter int unsigned LEN_W = 8,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LANES-1:0] cond_i,
  input  logic [LANES-1:0] entry_mask_i,
  input  logic [LEN_W-1:0] then_len_i,
  input  logic [LEN_W-1:0] else_len_i,
  output logic [LANES-1:0] mask_o,
  output logic [1:0]       phase_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] useful_o,
  output logic [CNT_W-1:0] total_o
);
  phase_e phase;
  logic   load, then_any, else_any;

  sbm_phase_seq #(.LEN_W(LEN_W)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .then_any_i(then_any), .else_any_i(else_any),
    .then_len_i, .else_len_i,
    .load_o(load), .phase_o(phase)
  );

  sbm_mask_split #(.LANES(LANES)) u_split (
    .clk_i, .rst_ni, .load_i(load), .cond_i, .entry_i(entry_mask_i),
    .phase_i(phase), .then_any_o(then_any), .else_any_o(else_any), .mask_o
  );

  sbm_util_count #(.LANES(LANES), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .phase_i(phase), .mask_i(mask_o), .useful_o, .total_o
  );

  assign phase_o = phase;
  assign busy_o  = (phase != PH_IDLE);

  a_r5_then_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase == PH_THEN |-> mask_o != '0);
  a_r5_else_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase == PH_ELSE |-> mask_o != '0);
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase == PH_IDLE |-> mask_o == '0);
  a_r8_useful_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    useful_o <= total_o);
endmodule

// File: tb/sim_simd_branch_mask.sv
`timescale 1ns/1ps
module sim_simd_branch_mask;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cond = '0, entry = '0, tlen = '0, elen = '0;
  logic [7:0]  mask;
  logic [1:0]  phase;
  logic        busy;
  logic [31:0] useful, total;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  simd_branch_mask u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cond_i(cond),
    .entry_mask_i(entry), .then_len_i(tlen), .else_len_i(elen),
    .mask_o(mask), .phase_o(phase), .busy_o(busy),
    .useful_o(useful), .total_o(total)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pc(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(v[i]);
    return c;
  endfunction

  // Runs one region; checks phase/mask/busy every cycle and counter deltas.
  task automatic run_branch(input string req, input logic [7:0] e, input logic [7:0] c,
                            input int tl, input int el, input bit poke);
    logic [7:0] tm, em;
    int tcyc, ecyc, cyc;
    longint u0v, t0v, eu, et;
    tm = c & e; em = ~c & e;
    tcyc = (tm != 0) ? tl : 0;
    ecyc = (em != 0) ? el : 0;
    u0v = useful; t0v = total;
    eu = tcyc * pc(tm) + ecyc * pc(em) + pc(e);
    et = 8 * (tcyc + ecyc + 1);
    @(negedge clk);
    entry = e; cond = c; tlen = 8'(tl); elen = 8'(el); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    for (int i = 0; i < tcyc; i++) begin
      chk({req, " then phase"}, phase, 1);
      chk({req, " then mask R6"}, mask, tm);
      chk("R9 busy", busy, 1);
      if (poke && cyc == 0) begin start = 1'b1; cond = ~c; entry = 8'hFF; end
      @(negedge clk); start = 1'b0; cyc++;
    end
    for (int i = 0; i < ecyc; i++) begin
      chk({req, " R3 else phase"}, phase, 2);
      chk({req, " R3 else mask R6"}, mask, em);
      if (poke && cyc == 0) begin start = 1'b1; cond = ~c; entry = 8'hFF; end
      @(negedge clk); start = 1'b0; cyc++;
    end
    chk({req, " R4 join phase"}, phase, 3);
    chk({req, " R4 join mask"}, mask, e);
    @(negedge clk);
    chk({req, " R4 back idle"}, phase, 0);
    chk({req, " R9 idle mask"}, mask, 0);
    chk({req, " R8 useful"}, useful - u0v, eu);
    chk({req, " R8 total"}, total - t0v, et);
  endtask

  task automatic t_reset();
    chk("R1 phase", phase, 0);
    chk("R1 mask", mask, 0);
    chk("R1 busy", busy, 0);
    chk("R1 useful", useful, 0);
    chk("R1 total", total, 0);
  endtask

  task automatic t_idle_hold();
    longint u, t;
    u = useful; t = total;
    repeat (4) @(negedge clk);
    chk("R8 idle hold useful", useful, u);
    chk("R8 idle hold total", total, t);
    chk("R9 idle busy", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    run_branch("R2 split", 8'hFF, 8'b1110_0000, 3, 2, 1'b0);
    run_branch("R2 one lane", 8'hFF, 8'b0000_0001, 4, 4, 1'b0);
    run_branch("R5 all true", 8'hFF, 8'hFF, 3, 5, 1'b0);
    run_branch("R5 all false", 8'hFF, 8'h00, 3, 2, 1'b0);
    run_branch("R5 zero then len", 8'hFF, 8'h0F, 0, 3, 1'b0);
    run_branch("R5 zero else len", 8'hFF, 8'h0F, 2, 0, 1'b0);
    run_branch("R5 empty entry", 8'h00, 8'h5A, 3, 3, 1'b0);
    run_branch("R6 partial entry", 8'b0011_1100, 8'b1010_1010, 2, 3, 1'b0);
    run_branch("R7 busy start", 8'hF0, 8'hC3, 3, 3, 1'b1);
    t_idle_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule